// File: doc/BRIEF.md
# SPI Master with Guarded Chip-Select Strobe

This block is a single-frame SPI master. A one-cycle start pulse latches a frame word, a frame size, the clock polarity and phase, and two guard-delay settings. It then pulls the active-low chip select, clocks out 8 to 16 bits MSB first on SOUT, and shifts the SIN bits into a right-aligned receive word. A one-cycle done pulse marks the end of the frame. SCK runs at the system clock divided by a fixed even parameter.

Next to the chip select the block drives an active-low strobe for external select decoding. The strobe opens one system clock after chip select falls. It leads the first SCK edge by a programmable number of clocks, and it closes one clock after the last SCK edge. Chip select then stays low for a second programmable number of clocks. Each guard length is an odd divide (1, 3, 5 or 7) times a power-of-two scaler (1, 2, 4 or 8). In continuous-clock mode the strobe is held inactive, while the guard timing of chip select stays the same.

Top module: `spi_strobe_master`

## Requirements
- R1: After reset, cs_n and strobe_n are 1, done is 0 and rx_word is 0.
- R2: While idle, sck follows the cpol input with one clock of latency. When cs_n rises at the end of a frame, sck is at the polarity latched for that frame.
- R3: With cpha=0, sout carries the first bit before the first SCK edge, the slave samples on odd edges (1, 3, ...) and sout changes on even edges. With cpha=1, sout changes on odd edges and the slave samples on even edges.
- R4: frame_size is the bit count minus one. Values below 7 give 8 bits. The low frame_size+1 bits of tx_word go out most significant bit first.
- R5: rx_word holds the SIN bits of the frame, first bit in the highest used position and right-aligned with the upper bits zero, and it is updated in the cycle done is high.
- R6: The lead guard, from strobe_n falling to the first SCK edge, is (2*lead_pre+1) << lead_scl system clocks. For example, code 3 with scaler code 0 gives 7 clocks.
- R7: strobe_n rises one clock after the last SCK edge. cs_n rises (2*lag_pre+1) << lag_scl clocks after strobe_n rises.
- R8: strobe_n falls exactly one clock after cs_n falls and is low only while cs_n is low. done is high for one clock, one clock after cs_n rises.
- R9: With cont_sck=1, strobe_n stays 1 for the whole frame. The first SCK edge comes 1 + lead guard clocks after cs_n falls, and cs_n rises 1 + lag guard clocks after the last SCK edge.
- R10: A start pulse while a frame is in progress has no effect: no second frame, and the running frame keeps its latched data and settings.
- R11: Each frame has exactly 2*N SCK edges for N bits, spaced SCK_DIV/2 system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle frame request, accepted only when idle |
| tx_word | input | MAX_BITS | Frame data, right-aligned |
| frame_size | input | SZ_W | Bits in frame minus one |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: sample on odd edges, 1: sample on even edges |
| cont_sck | input | 1 | Continuous-clock mode, strobe suppressed |
| lead_pre | input | PRE_W | Lead guard odd-divide code |
| lead_scl | input | SCL_W | Lead guard scaler code |
| lag_pre | input | PRE_W | Lag guard odd-divide code |
| lag_scl | input | SCL_W | Lag guard scaler code |
| sin | input | 1 | Serial data from slave |
| sck | output | 1 | Serial clock |
| sout | output | 1 | Serial data to slave |
| cs_n | output | 1 | Active-low chip select |
| strobe_n | output | 1 | Active-low guarded select strobe |
| rx_word | output | MAX_BITS | Received frame, right-aligned |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A slave model in the bench samples sout and drives sin on the edges that cpol and cpha select. If the phase handling were swapped, the model would read bits shifted by one position. The bench times every strobe and chip-select transition against the SCK edges for each guard code and scaler, including the largest guard of 56 clocks. An off-by-one in the lead or lag counters would show as a one-clock error, and a swapped lead and lag field as a wrong guard length. Frame sizes below eight test the clamp. Continuous-clock frames confirm that the strobe never moves while the guard timing holds. A start pulse during a frame would produce a second chip-select fall or corrupted data if it were not ignored.

// File: rtl/sss_pkg.sv
package sss_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_LEAD,
      ST_SHIFT,
      ST_REL,
      ST_LAG,
      ST_FIN
   } seq_st_e;

   // Largest guard length in system clocks for given code widths.
   function automatic int guard_max(input int pre_w, input int scl_w);
      return (2 * ((2 ** pre_w) - 1) + 1) * (2 ** ((2 ** scl_w) - 1));
   endfunction

endpackage

// File: rtl/sss_guard_calc.sv
module sss_guard_calc #(
   parameter int PRE_W = 2,
   parameter int SCL_W = 2,
   parameter int DLY_W = 6
) (
   input  logic [PRE_W-1:0] pre_code,
   input  logic [SCL_W-1:0] scl_code,
   output logic [DLY_W-1:0] cycles
);

   // Odd divide 2*code+1, then scaled by a power of two.
   logic [DLY_W-1:0] odd_div;

   assign odd_div = DLY_W'({pre_code, 1'b1});
   assign cycles  = odd_div << scl_code;

endmodule

// File: rtl/sss_sck_gen.sv
module sss_sck_gen #(
   parameter int SCK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle,
   input  logic cpol_in,
   input  logic kick,
   input  logic run,
   output logic sck,
   output logic edge_fire
);

   localparam int HALF = SCK_DIV / 2;
   localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;

   logic [HC_W-1:0] hcnt;

   assign edge_fire = kick | (run && (hcnt == HC_W'(HALF - 1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck  <= 1'b0;
         hcnt <= '0;
      end else begin
         if (idle) begin
            sck <= cpol_in;
         end else if (edge_fire) begin
            sck <= ~sck;
         end
         if (!run || edge_fire) begin
            hcnt <= '0;
         end else begin
            hcnt <= hcnt + HC_W'(1);
         end
      end
   end

   // R11: consecutive SCK edges are never in adjacent system clocks
   p_edge_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      edge_fire |=> !edge_fire);

   // R11: SCK moves only on an edge or while idle
   p_sck_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !edge_fire) |=> $stable(sck));

endmodule

// File: rtl/sss_shifter.sv
module sss_shifter #(
   parameter int MAX_BITS = 16,
   parameter int BC_W     = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                cpha_in,
   input  logic [BC_W-1:0]     nbits_in,
   input  logic [MAX_BITS-1:0] tx_in,
   input  logic                sin,
   input  logic                sample_now,
   input  logic                launch_now,
   input  logic                fin,
   output logic                sout,
   output logic [MAX_BITS-1:0] rx_word
);

   logic [MAX_BITS-1:0] tx_sh;
   logic [MAX_BITS-1:0] rx_sh;
   logic [MAX_BITS-1:0] aligned;

   // Left-justify the used bits so the first bit sits at the top.
   assign aligned = tx_in << (BC_W'(MAX_BITS) - nbits_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh   <= '0;
         rx_sh   <= '0;
         sout    <= 1'b0;
         rx_word <= '0;
      end else begin
         if (load) begin
            rx_sh <= '0;
            if (!cpha_in) begin
               sout  <= aligned[MAX_BITS-1];
               tx_sh <= aligned << 1;
            end else begin
               sout  <= 1'b0;
               tx_sh <= aligned;
            end
         end else begin
            if (launch_now) begin
               sout  <= tx_sh[MAX_BITS-1];
               tx_sh <= tx_sh << 1;
            end
            if (sample_now) begin
               rx_sh <= {rx_sh[MAX_BITS-2:0], sin};
            end
         end
         if (fin) begin
            rx_word <= rx_sh;
         end
      end
   end

   // R5: received word changes only at the end of a frame
   p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> $stable(rx_word));

   // R3: an edge is either a sample or a launch, never both
   p_edge_role_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_now && launch_now));

endmodule

// File: rtl/sss_seq.sv
module sss_seq
   import sss_pkg::*;
#(
   parameter int MAX_BITS = 16,
   parameter int MIN_BITS = 8,
   parameter int SZ_W     = 4,
   parameter int BC_W     = 5,
   parameter int EC_W     = 6,
   parameter int DLY_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cpol_in,
   input  logic             cpha_in,
   input  logic             cont_in,
   input  logic [SZ_W-1:0]  size_in,
   input  logic [DLY_W-1:0] lead_in,
   input  logic [DLY_W-1:0] lag_in,
   input  logic             edge_fire,
   output logic             cs_n,
   output logic             stb_n,
   output logic             done,
   output logic             load,
   output logic             kick,
   output logic             run,
   output logic             idle,
   output logic             fin,
   output logic             cpol_q,
   output logic             sample_now,
   output logic             launch_now,
   output logic [BC_W-1:0]  nb_next
);

   seq_st_e          st;
   logic             cpha_q;
   logic             cont_q;
   logic [BC_W-1:0]  nbits_q;
   logic [DLY_W-1:0] lead_q;
   logic [DLY_W-1:0] lag_q;
   logic [DLY_W-1:0] tmr;
   logic [EC_W-1:0]  ecnt;
   logic [BC_W-1:0]  size_p1;
   logic             last_edge;

   assign size_p1 = BC_W'(size_in) + BC_W'(1);
   assign nb_next = (size_p1 < BC_W'(MIN_BITS)) ? BC_W'(MIN_BITS) : size_p1;

   assign idle       = (st == ST_IDLE);
   assign fin        = (st == ST_FIN);
   assign load       = idle && start;
   assign kick       = (st == ST_LEAD) && (tmr == '0);
   assign run        = (st == ST_SHIFT);
   assign sample_now = edge_fire && (ecnt[0] == cpha_q);
   assign launch_now = edge_fire && (ecnt[0] != cpha_q);
   assign last_edge  = edge_fire && (ecnt == ({1'b0, nbits_q, 1'b0} - EC_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cs_n    <= 1'b1;
         stb_n   <= 1'b1;
         done    <= 1'b0;
         cpol_q  <= 1'b0;
         cpha_q  <= 1'b0;
         cont_q  <= 1'b0;
         nbits_q <= BC_W'(MIN_BITS);
         lead_q  <= DLY_W'(1);
         lag_q   <= DLY_W'(1);
         tmr     <= '0;
         ecnt    <= '0;
      end else begin
         done <= 1'b0;
         if (edge_fire) begin
            ecnt <= ecnt + EC_W'(1);
         end
         case (st)
            ST_IDLE: begin
               if (start) begin
                  cs_n    <= 1'b0;
                  cpol_q  <= cpol_in;
                  cpha_q  <= cpha_in;
                  cont_q  <= cont_in;
                  nbits_q <= nb_next;
                  lead_q  <= lead_in;
                  lag_q   <= lag_in;
                  ecnt    <= '0;
                  st      <= ST_ARM;
               end
            end
            ST_ARM: begin
               stb_n <= cont_q;
               tmr   <= lead_q - DLY_W'(1);
               st    <= ST_LEAD;
            end
            ST_LEAD: begin
               if (tmr == '0) begin
                  st <= ST_SHIFT;
               end else begin
                  tmr <= tmr - DLY_W'(1);
               end
            end
            ST_SHIFT: begin
               if (last_edge) begin
                  st <= ST_REL;
               end
            end
            ST_REL: begin
               stb_n <= 1'b1;
               tmr   <= lag_q - DLY_W'(1);
               st    <= ST_LAG;
            end
            ST_LAG: begin
               if (tmr == '0) begin
                  cs_n <= 1'b1;
                  st   <= ST_FIN;
               end else begin
                  tmr <= tmr - DLY_W'(1);
               end
            end
            ST_FIN: begin
               done <= 1'b1;
               st   <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R9: continuous-clock frames keep the strobe inactive
   p_cont_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cont_q |-> stb_n);

   // R10: a start during a frame never re-arms the sequence
   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && start) |=> (st != ST_ARM));

   // R8: done lasts a single clock
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/spi_strobe_master.sv
module spi_strobe_master #(
   parameter  int MAX_BITS = 16,
   parameter  int MIN_BITS = 8,
   parameter  int SCK_DIV  = 4,
   parameter  int PRE_W    = 2,
   parameter  int SCL_W    = 2,
   localparam int SZ_W     = $clog2(MAX_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [MAX_BITS-1:0] tx_word,
   input  logic [SZ_W-1:0]     frame_size,
   input  logic                cpol,
   input  logic                cpha,
   input  logic                cont_sck,
   input  logic [PRE_W-1:0]    lead_pre,
   input  logic [SCL_W-1:0]    lead_scl,
   input  logic [PRE_W-1:0]    lag_pre,
   input  logic [SCL_W-1:0]    lag_scl,
   input  logic                sin,
   output logic                sck,
   output logic                sout,
   output logic                cs_n,
   output logic                strobe_n,
   output logic [MAX_BITS-1:0] rx_word,
   output logic                done
);

   localparam int BC_W   = $clog2(MAX_BITS + 1);
   localparam int EC_W   = BC_W + 1;
   localparam int DLY_W  = $clog2(sss_pkg::guard_max(PRE_W, SCL_W) + 1);
   localparam int N_GRD  = 2;

   if ((SCK_DIV < 4) || ((SCK_DIV % 2) != 0)) begin : g_bad_div
      $error("SCK_DIV must be even and at least 4");
   end
   if ((MIN_BITS < 2) || (MIN_BITS > MAX_BITS)) begin : g_bad_min
      $error("MIN_BITS must lie in 2..MAX_BITS");
   end
   if ((1 << SZ_W) != MAX_BITS) begin : g_bad_max
      $error("MAX_BITS must be a power of two");
   end

   logic [PRE_W-1:0] pre_codes [N_GRD];
   logic [SCL_W-1:0] scl_codes [N_GRD];
   logic [DLY_W-1:0] grd_cyc   [N_GRD];

   assign pre_codes[0] = lead_pre;
   assign scl_codes[0] = lead_scl;
   assign pre_codes[1] = lag_pre;
   assign scl_codes[1] = lag_scl;

   for (genvar g = 0; g < N_GRD; g++) begin : g_guard
      sss_guard_calc #(
         .PRE_W (PRE_W),
         .SCL_W (SCL_W),
         .DLY_W (DLY_W)
      ) u_calc (
         .pre_code (pre_codes[g]),
         .scl_code (scl_codes[g]),
         .cycles   (grd_cyc[g])
      );
   end

   logic            load, kick, run, idle, fin, edge_fire;
   logic            cpol_q, sample_now, launch_now;
   logic [BC_W-1:0] nb_next;

   sss_seq #(
      .MAX_BITS (MAX_BITS),
      .MIN_BITS (MIN_BITS),
      .SZ_W     (SZ_W),
      .BC_W     (BC_W),
      .EC_W     (EC_W),
      .DLY_W    (DLY_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cpol_in    (cpol),
      .cpha_in    (cpha),
      .cont_in    (cont_sck),
      .size_in    (frame_size),
      .lead_in    (grd_cyc[0]),
      .lag_in     (grd_cyc[1]),
      .edge_fire  (edge_fire),
      .cs_n       (cs_n),
      .stb_n      (strobe_n),
      .done       (done),
      .load       (load),
      .kick       (kick),
      .run        (run),
      .idle       (idle),
      .fin        (fin),
      .cpol_q     (cpol_q),
      .sample_now (sample_now),
      .launch_now (launch_now),
      .nb_next    (nb_next)
   );

   sss_sck_gen #(
      .SCK_DIV (SCK_DIV)
   ) u_sck (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle      (idle),
      .cpol_in   (cpol),
      .kick      (kick),
      .run       (run),
      .sck       (sck),
      .edge_fire (edge_fire)
   );

   sss_shifter #(
      .MAX_BITS (MAX_BITS),
      .BC_W     (BC_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .cpha_in    (cpha),
      .nbits_in   (nb_next),
      .tx_in      (tx_word),
      .sin        (sin),
      .sample_now (sample_now),
      .launch_now (launch_now),
      .fin        (fin),
      .sout       (sout),
      .rx_word    (rx_word)
   );

   // R8: the strobe is only ever active inside chip select
   p_stb_in_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_n |-> !cs_n);

   // R8: done follows a clock in which chip select was already released
   p_done_after_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && $past(cs_n)));

   // R2: SCK rests at the latched polarity when chip select releases
   p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (sck == cpol_q));

endmodule

// File: tb/sim_spi_strobe_master.sv
module sim_spi_strobe_master;

   localparam int HALF = 2;

   typedef struct packed {
      logic [15:0] tx;
      logic [3:0]  sz;
      logic        cpol;
      logic        cpha;
      logic [1:0]  lp;
      logic [1:0]  ls;
      logic [1:0]  gp;
      logic [1:0]  gs;
      logic        cont;
      logic [15:0] pat;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{16'hA5C3, 4'd15, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 16'h3C5A},
      '{16'h00B7, 4'd7,  1'b0, 1'b1, 2'd1, 2'd1, 2'd2, 2'd0, 1'b0, 16'h00E1},
      '{16'h1234, 4'd11, 1'b1, 1'b0, 2'd3, 2'd0, 2'd1, 2'd2, 1'b0, 16'h0ABC},
      '{16'h8001, 4'd15, 1'b1, 1'b1, 2'd3, 2'd3, 2'd3, 2'd3, 1'b0, 16'h7FFE},
      '{16'h0055, 4'd3,  1'b0, 1'b0, 2'd2, 2'd2, 2'd0, 2'd3, 1'b0, 16'h00AA},
      '{16'h6E2F, 4'd13, 1'b1, 1'b0, 2'd1, 2'd0, 2'd0, 2'd1, 1'b1, 16'h1F0F},
      '{16'h0F0F, 4'd9,  1'b0, 1'b1, 2'd0, 2'd3, 2'd3, 2'd0, 1'b1, 16'h0333}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] tx_word = '0;
   logic [3:0]  frame_size = '0;
   logic        cpol = 1'b0, cpha = 1'b0, cont_sck = 1'b0;
   logic [1:0]  lead_pre = '0, lead_scl = '0, lag_pre = '0, lag_scl = '0;
   logic        sin = 1'b0;
   logic        sck, sout, cs_n, strobe_n, done;
   logic [15:0] rx_word;

   always #4 clk = ~clk;

   spi_strobe_master u0 (
      .clk (clk), .rst_n (rst_n), .start (start), .tx_word (tx_word),
      .frame_size (frame_size), .cpol (cpol), .cpha (cpha), .cont_sck (cont_sck),
      .lead_pre (lead_pre), .lead_scl (lead_scl), .lag_pre (lag_pre), .lag_scl (lag_scl),
      .sin (sin), .sck (sck), .sout (sout), .cs_n (cs_n), .strobe_n (strobe_n),
      .rx_word (rx_word), .done (done)
   );

   int errs = 0, checks = 0, cyc = 0;
   bit ended = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, what, act, act, exp, exp);
      end
   endtask

   // Monitor and slave model, evaluated away from the active edge.
   int n_csf, n_csr, n_stf, n_str, ne, n_done, jidx;
   int t_csf, t_csr, t_stf, t_str, t_sck1, t_sckl, t_done;
   logic [15:0] got_sout, rx_seen, m_pat;
   int m_n;
   logic m_cpha;
   logic pcs = 1'b1, pstb = 1'b1, psck = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (pcs && !cs_n) begin
         n_csf++; t_csf = cyc;
         if (!m_cpha) begin sin = m_pat[m_n-1]; jidx = 1; end
         else jidx = 0;
      end
      if (!pcs && cs_n) begin n_csr++; t_csr = cyc; end
      if (pstb && !strobe_n) begin n_stf++; t_stf = cyc; end
      if (!pstb && strobe_n) begin n_str++; t_str = cyc; end
      if (!cs_n && (sck != psck)) begin
         ne++;
         if (ne == 1) t_sck1 = cyc;
         t_sckl = cyc;
         if (((ne % 2) == 1) != m_cpha) begin
            got_sout = {got_sout[14:0], sout};
         end else begin
            sin = (jidx < m_n) ? m_pat[m_n-1-jidx] : 1'b0;
            jidx++;
         end
      end
      if (done) begin n_done++; t_done = cyc; rx_seen = rx_word; end
      pcs = cs_n; pstb = strobe_n; psck = sck;
   end

   always @(posedge clk) begin
      if (cyc > 150000 && !ended) begin
         ended = 1;
         checks++; errs++;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   task automatic run_frame(input vec_t v, input bit mid);
      int nb, lead, lag, mask;
      nb   = (int'(v.sz) + 1 < 8) ? 8 : int'(v.sz) + 1;
      lead = (2 * int'(v.lp) + 1) << v.ls;
      lag  = (2 * int'(v.gp) + 1) << v.gs;
      mask = (1 << nb) - 1;
      @(posedge clk); #2;
      tx_word = v.tx; frame_size = v.sz; cpol = v.cpol; cpha = v.cpha; cont_sck = v.cont;
      lead_pre = v.lp; lead_scl = v.ls; lag_pre = v.gp; lag_scl = v.gs;
      n_csf = 0; n_csr = 0; n_stf = 0; n_str = 0; ne = 0; n_done = 0; jidx = 0;
      got_sout = '0; rx_seen = '0; m_pat = v.pat; m_n = nb; m_cpha = v.cpha;
      repeat (3) @(posedge clk); #2;
      start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
      if (mid) begin
         repeat (12) @(posedge clk); #2;
         tx_word = ~v.tx; frame_size = 4'd15; lead_pre = 2'd3; start = 1'b1;
         @(posedge clk); #2;
         start = 1'b0;
      end
      for (int i = 0; i < 3000 && n_done == 0; i++) @(posedge clk);
      repeat (40) @(posedge clk); #2;
      chk("R5", "rx_word", int'(rx_seen), int'(v.pat) & mask);
      chk("R4", "sout bits", int'(got_sout) & mask, int'(v.tx) & mask);
      chk("R3", "sout width", int'(got_sout) >> nb, 0);
      chk("R11", "edge count", ne, 2 * nb);
      chk("R11", "edge span", t_sckl - t_sck1, (2 * nb - 1) * HALF);
      if (!v.cont) begin
         chk("R8", "strobe after cs", t_stf - t_csf, 1);
         chk("R6", "lead guard", t_sck1 - t_stf, lead);
         chk("R7", "strobe release", t_str - t_sckl, 1);
         chk("R7", "lag guard", t_csr - t_str, lag);
      end else begin
         chk("R9", "strobe falls", n_stf, 0);
         chk("R9", "cont lead", t_sck1 - t_csf, 1 + lead);
         chk("R9", "cont lag", t_csr - t_sckl, 1 + lag);
      end
      chk("R8", "done after cs", t_done - t_csr, 1);
      chk("R8", "done pulses", n_done, 1);
      chk("R2", "sck rest", int'(sck), int'(v.cpol));
      if (mid) chk("R10", "cs falls", n_csf, 1);
   endtask

   initial begin
      m_pat = '0; m_n = 8; m_cpha = 1'b0;
      repeat (3) @(posedge clk); #2;
      chk("R1", "cs_n in reset", int'(cs_n), 1);
      rst_n = 1'b1;
      repeat (2) @(posedge clk); #2;
      chk("R1", "cs_n", int'(cs_n), 1);
      chk("R1", "strobe_n", int'(strobe_n), 1);
      chk("R1", "done", int'(done), 0);
      chk("R1", "rx_word", int'(rx_word), 0);
      chk("R2", "idle sck low", int'(sck), 0);
      cpol = 1'b1;
      repeat (2) @(posedge clk); #2;
      chk("R2", "idle sck follows cpol", int'(sck), 1);
      cpol = 1'b0;
      repeat (2) @(posedge clk); #2;
      chk("R2", "idle sck back low", int'(sck), 0);

      for (int k = 0; k < NV; k++) run_frame(VECS[k], 1'b0);

      // R10: second start mid-frame is ignored
      run_frame(VECS[1], 1'b1);
      // R4: clamp of a tiny size with phase 1
      run_frame('{16'h00C6, 4'd0, 1'b1, 1'b1, 2'd0, 2'd1, 2'd1, 2'd0, 1'b0, 16'h0039}, 1'b0);

      ended = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule